// File: doc/BRIEF.md
# Interleaved Component Video Byte Splitter

This block takes a single byte-wide stream that carries luma and two colour-difference components in 4:2:2 form, one byte per clock at the pixel-port rate, with timing markers embedded in the data. It separates the stream into a luma path and a paired chroma path. Each path has its own valid strobe. It also pulls the field, vertical-blank and horizontal-blank state out of the embedded markers, so that downstream stages can lock their line and field counters to the incoming video instead of to separate sync wires.

A timing marker is four bytes: all ones, all zeros, all zeros, then a flag byte. In the flag byte, bit 6 carries the field, bit 5 the vertical blank and bit 4 the line-position flag. A zero in bit 4 marks the start of active samples and a one marks their end. Between a start marker and the next end marker, bytes arrive in the order Cb, Y, Cr, Y and repeat. Outside that span, bytes are ignored. The two extreme codes are reserved for markers, so any data byte that carries one of them is pulled in to the nearest legal value. The block looks back over a four-byte window before it decides whether a byte is data or part of a marker. Each byte therefore leaves the block five clock cycles after it is sampled.

Top module: `pixel_port_demux`

## Requirements
- R1: The four-byte sequence 0xFF, 0x00, 0x00, XY is recognised as a timing marker. If bit 4 of XY is 0, `sav_pulse` goes high for exactly one cycle. If bit 4 is 1, `eav_pulse` goes high for exactly one cycle. Markers reach these pulses in the order they arrive.
- R2: `field`, `vblank` and `hblank` take bits 6, 5 and 4 of the latest marker's XY byte in the same cycle as that marker's pulse. They hold those values until the next marker.
- R3: After each start marker, data bytes are assigned in the repeating order Cb, Y, Cr, Y. The order restarts at Cb on every start marker, even when the previous line ended partway through a group.
- R4: `y_valid` is high for one cycle for each luma byte, with the value on `y_out`. `c_valid` is high for one cycle for each completed Cb/Cr pair, in the cycle after the pair's first luma. At that point `cb_out` and `cr_out` hold that pair, and `cb_out` has not changed since the previous cycle.
- R5: A data byte of 0x00 is output as 0x01, and a data byte of 0xFF is output as 0xFE. Every other value passes through unchanged.
- R6: An incomplete marker prefix inside active video is treated as ordinary data, with the substitution of R5 applied. Examples are 0xFF, 0x00 followed by a non-zero byte, or 0xFF followed by a non-zero byte.
- R7: Bytes between an end marker and the next start marker do not assert `y_valid` or `c_valid`, whatever their value.
- R8: During reset, and in the first cycle after it, all outputs are zero.
- R9: `y_valid` and `c_valid` are never high together. `sav_pulse` and `eav_pulse` are never high together.
- R10: Samples between a start and an end marker are output even when the marker's vertical-blank bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-port clock, one byte per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | DATA_W | Interleaved component byte stream |
| y_out | output | DATA_W | Latest luma sample |
| cb_out | output | DATA_W | Blue-difference sample of the current pair |
| cr_out | output | DATA_W | Red-difference sample of the current pair |
| y_valid | output | 1 | One-cycle strobe per luma sample |
| c_valid | output | 1 | One-cycle strobe per completed chroma pair |
| field | output | 1 | Field bit of the latest marker |
| vblank | output | 1 | Vertical-blank bit of the latest marker |
| hblank | output | 1 | Line-position bit of the latest marker |
| sav_pulse | output | 1 | One-cycle pulse on a start-of-active marker |
| eav_pulse | output | 1 | One-cycle pulse on an end-of-active marker |

## Verification
The bench builds the block with the default DATA_W of 8. With that width the all-ones and all-zeros codes are 0xFF and 0x00, and the marker flags sit at bits 6, 5 and 4, so marker bytes can be written exactly as a real 8-bit stream carries them. At this width the stimulus can place reserved codes in active data, in blanking, and inside broken marker prefixes. It can also cut a line off partway through a Cb/Y/Cr/Y group and send lines with the vertical-blank bit set, each alongside the expected clamped value.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

  // Position of a data byte inside the repeating 4:2:2 group.
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_YA = 2'd1,
    PH_CR = 2'd2,
    PH_YB = 2'd3
  } phase_e;

  // Flags carried by the last byte of a timing marker.
  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_flags_t;

endpackage

// File: rtl/ppd_trs_detect.sv
module ppd_trs_detect
  import ppd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] tail_byte,
  output logic          tail_is_trs,
  output logic          xy_done,
  output trs_flags_t    xy_flags
);

  localparam int TRS_LEN = 4;
  localparam int CNT_W = $clog2(TRS_LEN);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};
  localparam logic [DW-1:0] ZERO = {DW{1'b0}};
  localparam int F_POS = DW - 2;
  localparam int V_POS = DW - 3;
  localparam int H_POS = DW - 4;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TRS_LEN - 1);

  // Look-behind window: win[0] is the newest byte, win[TRS_LEN-1] the oldest.
  logic [DW-1:0] win [TRS_LEN];

  generate
    for (genvar i = 0; i < TRS_LEN; i++) begin : g_win
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) win[i] <= ZERO;
          else        win[i] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) win[i] <= ZERO;
          else        win[i] <= win[i-1];
        end
      end
    end
  endgenerate

  function automatic logic is_preamble(input logic [DW-1:0] a,
                                       input logic [DW-1:0] b,
                                       input logic [DW-1:0] c);
    return (a == ONES) && (b == ZERO) && (c == ZERO);
  endfunction

  function automatic trs_flags_t decode_xy(input logic [DW-1:0] xy);
    trs_flags_t fl;
    fl.f = xy[F_POS];
    fl.v = xy[V_POS];
    fl.h = xy[H_POS];
    return fl;
  endfunction

  logic [CNT_W-1:0] trs_left;
  trs_flags_t       xy_reg;
  logic             trs_start;

  // A marker starts when its first byte reaches the tail of the window.
  assign trs_start = is_preamble(win[TRS_LEN-1], win[TRS_LEN-2], win[TRS_LEN-3])
                     && (trs_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trs_left <= '0;
      xy_reg   <= '0;
    end else if (trs_start) begin
      trs_left <= RELOAD;
      xy_reg   <= decode_xy(win[0]);
    end else if (trs_left != '0) begin
      trs_left <= trs_left - CNT_W'(1);
    end
  end

  assign tail_byte   = win[TRS_LEN-1];
  assign tail_is_trs = trs_start || (trs_left != '0);
  assign xy_done     = (trs_left == CNT_W'(1));
  assign xy_flags    = xy_reg;

  AST_MARKER_SPANS: assert property (@(posedge clk) disable iff (!rst_n)
    trs_start |=> tail_is_trs && !xy_done) else $error("marker span broken"); // R1

endmodule

// File: rtl/ppd_timing_flags.sv
module ppd_timing_flags
  import ppd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xy_done,
  input  trs_flags_t xy_flags,
  output logic       field,
  output logic       vblank,
  output logic       hblank,
  output logic       sav_pulse,
  output logic       eav_pulse,
  output logic       active,
  output logic       sav_seen
);

  logic eav_seen;

  assign sav_seen = xy_done && !xy_flags.h;
  assign eav_seen = xy_done &&  xy_flags.h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field     <= 1'b0;
      vblank    <= 1'b0;
      hblank    <= 1'b0;
      sav_pulse <= 1'b0;
      eav_pulse <= 1'b0;
      active    <= 1'b0;
    end else begin
      sav_pulse <= sav_seen;
      eav_pulse <= eav_seen;
      if (xy_done) begin
        field  <= xy_flags.f;
        vblank <= xy_flags.v;
        hblank <= xy_flags.h;
        active <= !xy_flags.h;
      end
    end
  end

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sav_pulse && eav_pulse)) else $error("both pulses high"); // R9
  AST_SAV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sav_pulse |=> !sav_pulse) else $error("sav pulse too long"); // R1
  AST_EAV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eav_pulse |=> !eav_pulse) else $error("eav pulse too long"); // R1
  AST_SAV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sav_pulse |-> !hblank) else $error("hblank high on start"); // R2
  AST_EAV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eav_pulse |-> hblank) else $error("hblank low on end"); // R2

endmodule

// File: rtl/ppd_sample_split.sv
module ppd_sample_split
  import ppd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tail_byte,
  input  logic          tail_is_trs,
  input  logic          active,
  input  logic          sav_seen,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] cb_out,
  output logic [DW-1:0] cr_out,
  output logic          y_valid,
  output logic          c_valid
);

  localparam logic [DW-1:0] MAXC = {DW{1'b1}};
  localparam logic [DW-1:0] MINC = {DW{1'b0}};
  localparam logic [DW-1:0] LO_LEGAL = MINC + DW'(1);
  localparam logic [DW-1:0] HI_LEGAL = MAXC - DW'(1);

  function automatic logic [DW-1:0] legalize(input logic [DW-1:0] v);
    if (v == MAXC) return HI_LEGAL;
    if (v == MINC) return LO_LEGAL;
    return v;
  endfunction

  phase_e        phase;
  logic          take;
  logic [DW-1:0] sample;

  assign take   = active && !tail_is_trs;
  assign sample = legalize(tail_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_CB;
      y_out   <= '0;
      cb_out  <= '0;
      cr_out  <= '0;
      y_valid <= 1'b0;
      c_valid <= 1'b0;
    end else begin
      y_valid <= 1'b0;
      c_valid <= 1'b0;
      if (sav_seen) begin
        phase <= PH_CB;
      end else if (take) begin
        unique case (phase)
          PH_CB: cb_out <= sample;
          PH_CR: begin
            cr_out  <= sample;
            c_valid <= 1'b1;
          end
          default: begin
            y_out   <= sample;
            y_valid <= 1'b1;
          end
        endcase
        phase <= phase_e'(phase + 2'd1);
      end
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(y_valid && c_valid)) else $error("both strobes high"); // R9
  AST_Y_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> (y_out != MAXC) && (y_out != MINC)) else $error("reserved luma"); // R5
  AST_C_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> (cb_out != MAXC) && (cb_out != MINC) && (cr_out != MAXC) && (cr_out != MINC))
    else $error("reserved chroma"); // R5
  AST_C_AFTER_Y: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> $past(y_valid)) else $error("chroma pair out of order"); // R3
  AST_CB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> $stable(cb_out)) else $error("cb moved under pair"); // R4

endmodule

// File: rtl/pixel_port_demux.sv
module pixel_port_demux
  import ppd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] cb_out,
  output logic [DATA_W-1:0] cr_out,
  output logic              y_valid,
  output logic              c_valid,
  output logic              field,
  output logic              vblank,
  output logic              hblank,
  output logic              sav_pulse,
  output logic              eav_pulse
);

  logic [DATA_W-1:0] tail_byte;
  logic              tail_is_trs;
  logic              xy_done;
  trs_flags_t        xy_flags;
  logic              active;
  logic              sav_seen;

  ppd_trs_detect #(.DW(DATA_W)) u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (din),
    .tail_byte   (tail_byte),
    .tail_is_trs (tail_is_trs),
    .xy_done     (xy_done),
    .xy_flags    (xy_flags)
  );

  ppd_timing_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .xy_done   (xy_done),
    .xy_flags  (xy_flags),
    .field     (field),
    .vblank    (vblank),
    .hblank    (hblank),
    .sav_pulse (sav_pulse),
    .eav_pulse (eav_pulse),
    .active    (active),
    .sav_seen  (sav_seen)
  );

  ppd_sample_split #(.DW(DATA_W)) u_split (
    .clk         (clk),
    .rst_n       (rst_n),
    .tail_byte   (tail_byte),
    .tail_is_trs (tail_is_trs),
    .active      (active),
    .sav_seen    (sav_seen),
    .y_out       (y_out),
    .cb_out      (cb_out),
    .cr_out      (cr_out),
    .y_valid     (y_valid),
    .c_valid     (c_valid)
  );

endmodule

// File: tb/pixel_port_demux_tb.sv
`timescale 1ns/1ps
module pixel_port_demux_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] din;
  logic [7:0] y_out, cb_out, cr_out;
  logic       y_valid, c_valid, field, vblank, hblank, sav_pulse, eav_pulse;

  always #2.5 clk = ~clk;

  pixel_port_demux #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
    .y_valid(y_valid), .c_valid(c_valid),
    .field(field), .vblank(vblank), .hblank(hblank),
    .sav_pulse(sav_pulse), .eav_pulse(eav_pulse)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Scoreboard queues filled by the driver
  logic [7:0]  q_y[$];
  string       q_ytag[$];
  logic [15:0] q_c[$];
  string       q_ctag[$];
  logic [2:0]  q_ev[$];   // {h, f, v}

  bit         m_active = 1'b0;
  int         m_phase = 0;
  logic [7:0] m_cb = 8'h00;
  string      cur_tag = "R3";
  logic [7:0] last_byte = 8'h00;
  logic       last_f = 1'b0, last_v = 1'b0;

  function automatic logic [7:0] legal(input logic [7:0] b);
    logic [7:0] r;
    r = b;
    if (b == 8'hFF) r = 8'hFE;
    else if (b == 8'h00) r = 8'h01;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    din = b;
    last_byte = b;
  endtask

  task automatic data(input logic [7:0] b);
    string t;
    t = ((b == 8'h00) || (b == 8'hFF)) ? "R5" : cur_tag;
    if (m_active) begin
      case (m_phase)
        0: m_cb = legal(b);
        2: begin q_c.push_back({m_cb, legal(b)}); q_ctag.push_back(t); end
        default: begin q_y.push_back(legal(b)); q_ytag.push_back(t); end
      endcase
      m_phase = (m_phase + 1) % 4;
    end
    put(b);
  endtask

  task automatic code(input logic f, input logic v, input logic h);
    logic [7:0] xy;
    xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    put(8'hFF); put(8'h00); put(8'h00); put(xy);
    q_ev.push_back({h, f, v});
    m_active = !h;
    if (!h) m_phase = 0;
    last_f = f; last_v = v;
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sav_pulse || eav_pulse) begin
        if (q_ev.size() == 0) chk(1'b0, "R1", "unexpected marker pulse", 1, 0);
        else begin
          logic [2:0] e;
          e = q_ev.pop_front();
          chk({eav_pulse, sav_pulse} == (e[2] ? 2'b10 : 2'b01), "R1", "pulse kind",
              {eav_pulse, sav_pulse}, e[2] ? 2 : 1);
          chk({field, vblank, hblank} == {e[1], e[0], e[2]}, "R2", "flags f/v/h",
              {field, vblank, hblank}, {e[1], e[0], e[2]});
        end
      end
      chk(!(y_valid && c_valid), "R9", "strobes together", {y_valid, c_valid}, 0);
      if (y_valid) begin
        if (q_y.size() == 0) chk(1'b0, "R7", "unexpected y_valid", y_out, 0);
        else begin
          logic [7:0] ey;
          string tg;
          ey = q_y.pop_front();
          tg = q_ytag.pop_front();
          chk(y_out == ey, tg, "luma", y_out, ey);
        end
      end
      if (c_valid) begin
        if (q_c.size() == 0) chk(1'b0, "R7", "unexpected c_valid", cr_out, 0);
        else begin
          logic [15:0] ec;
          string tg;
          ec = q_c.pop_front();
          tg = q_ctag.pop_front();
          chk({cb_out, cr_out} == ec, tg, "chroma pair", {cb_out, cr_out}, ec);
        end
      end
    end
  end

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) data((i % 2 == 0) ? 8'h80 : 8'h10);
  endtask

  initial begin
    logic [7:0] lfsr;
    logic [7:0] b;
    logic       fld;
    rst_n = 1'b0;
    din   = 8'h10;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk({y_out, cb_out, cr_out} == 24'h0, "R8", "data outputs in reset", y_out, 0);
    chk({y_valid, c_valid, field, vblank, hblank, sav_pulse, eav_pulse} == 7'h0, "R8",
        "flag outputs in reset", {y_valid, c_valid, field, vblank, hblank}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({y_valid, c_valid, sav_pulse, eav_pulse, field, vblank, hblank} == 7'h0, "R8",
        "outputs after reset", {y_valid, c_valid, sav_pulse, eav_pulse}, 0);

    // Blanking with reserved strays: R7
    cur_tag = "R7";
    blank(6); data(8'hFF); data(8'h00); data(8'h10); data(8'h00); data(8'hFF); data(8'h80);

    // Plain line with clamping: R3, R5
    code(1'b0, 1'b0, 1'b0);
    cur_tag = "R3";
    for (int i = 0; i < 16; i++) data(8'(i * 37 + 5));
    data(8'h00); data(8'hFF); data(8'hFF); data(8'h00);
    data(8'h01); data(8'hFE); data(8'h10); data(8'hEB);
    code(1'b0, 1'b0, 1'b1);
    cur_tag = "R7";
    data(8'h00); data(8'hFF); data(8'h55); blank(6);

    // Line ending partway through a group, then a restart: R3
    code(1'b0, 1'b0, 1'b0);
    cur_tag = "R3";
    for (int i = 0; i < 7; i++) data(8'(8'h20 + i));
    code(1'b0, 1'b0, 1'b1);
    blank(4);
    code(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) data(8'(8'h60 + i));
    code(1'b0, 1'b0, 1'b1);
    blank(4);

    // Broken marker prefixes inside active data: R6
    code(1'b0, 1'b0, 1'b0);
    cur_tag = "R6";
    data(8'h10); data(8'hFF); data(8'h00); data(8'h33);
    data(8'hFF); data(8'h44); data(8'h00); data(8'h00);
    data(8'hFF); data(8'h00); data(8'h01); data(8'h40);
    code(1'b0, 1'b0, 1'b1);
    blank(4);

    // Vertical-blank line still carries samples: R10
    code(1'b1, 1'b1, 1'b0);
    cur_tag = "R10";
    for (int i = 0; i < 12; i++) data(8'(8'h90 + 3 * i));
    code(1'b1, 1'b1, 1'b1);
    blank(5);

    // Pseudo-random lines: R3
    lfsr = 8'hA5;
    fld = 1'b0;
    for (int ln = 0; ln < 6; ln++) begin
      code(fld, 1'b0, 1'b0);
      cur_tag = "R3";
      for (int i = 0; i < 24 + 2 * ln; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        b = lfsr;
        if (i % 11 == 3) b = 8'hFF;
        if (last_byte == 8'hFF && b == 8'h00) b = 8'h01;
        data(b);
      end
      code(fld, 1'b0, 1'b1);
      cur_tag = "R7";
      blank(6);
      fld = ~fld;
    end

    blank(12);
    repeat (4) @(negedge clk);
    chk(q_y.size() == 0, "R4", "luma items left", q_y.size(), 0);
    chk(q_c.size() == 0, "R4", "chroma pairs left", q_c.size(), 0);
    chk(q_ev.size() == 0, "R1", "markers left", q_ev.size(), 0);
    chk({field, vblank, hblank} == {last_f, last_v, 1'b1}, "R2", "flags held",
        {field, vblank, hblank}, {last_f, last_v, 1'b1});
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule